// File: doc/BRIEF.md
# Idle mode and reset qualification controller

This block decides when the processor core of a small microcontroller is clocked. It also turns a noisy external reset pin into a clean internal reset. Software enters a low-power idle state by writing a control word whose bit 0 is 1. From the next cycle the core's clock enable drops, while the peripheral clock enable stays high so that timers, the serial port and the interrupt logic keep running.

An enabled, pending interrupt ends idle. The controller clears its idle bit in hardware, and the core clock enable returns in the following cycle, so the core can service the interrupt that woke it.

The external reset pin passes through a two-flop synchronizer. It must then stay high across two machine-cycle ticks before the internal reset asserts, so shorter glitches are dropped. The internal reset holds the core and peripheral enables low and clears the idle state. The asynchronous `rst_n` input is expected to come from the chip reset tree with a synchronous release.

Top module: `idle_reset_ctrl`

## Requirements
- R1: After `rst_n` is released with the pin low, `cpu_clk_en`=1, `per_clk_en`=1 and `int_rst`=0.
- R2: A write with `pwr_wdata[0]`=1 while the core is running, with no enabled interrupt pending and no internal reset, sets idle. `cpu_clk_en` is 0 from the cycle after the write and `per_clk_en` stays 1.
- R3: While idle, any bit set in both `irq_pending` and `irq_enable` clears idle, and `cpu_clk_en` is 1 in the next cycle. Pending bits whose enable is 0 have no effect.
- R4: Writes are ignored while idle, including a write with bit 0 equal to 0, because the core cannot issue writes then.
- R5: A write with bit 0 equal to 0 while running leaves the core running.
- R6: If an idle-entry write and an enabled pending interrupt occur in the same cycle, the interrupt wins and the core keeps running.
- R7: `int_rst` asserts at the clock edge where the second tick is seen while the synchronized pin is high. Ticks seen while the synchronized pin is still low do not count, and a pulse that ends before its second tick never asserts reset.
- R8: `int_rst` stays asserted while the pin stays high. It deasserts at the third clock edge after the pin falls.
- R9: While `int_rst` is 1, both clock enables are 0. The internal reset clears idle, so the core runs once the reset ends.
- R10: Writes made while `int_rst` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| pwr_we | input | 1 | Write strobe for the power-control word |
| pwr_wdata | input | 8 | Write data; bit 0 requests idle |
| irq_pending | input | N_IRQ | Pending interrupt flags |
| irq_enable | input | N_IRQ | Interrupt enable flags |
| ext_rst_pin | input | 1 | Raw external reset pin, active high |
| cpu_clk_en | output | 1 | Clock enable for the core |
| per_clk_en | output | 1 | Clock enable for peripherals and interrupt logic |
| int_rst | output | 1 | Qualified internal reset, active high |

## Verification
On every cycle the assertions check:
- that an idle-entry write gates the core on the next cycle;
- that an enabled interrupt restores the core on the next cycle;
- that idle holds when no enabled interrupt is pending;
- that both enables stay low during internal reset;
- that reset can only rise on a tick;
- that reset can only fall three cycles after a low pin.

Only the bench scenarios show the rest: that ticks arriving before the synchronizer settles are not counted, that a one-tick pulse is rejected, and that writes made during idle or during reset leave no trace once the core runs again.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned IRC_SYNC_STAGES = 2;
  localparam int unsigned IRC_MIN_TICKS   = 2;
  localparam int unsigned IRC_N_IRQ       = 4;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic rst;
  } irc_out_t;
endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[0] <= 1'b0;
        else        sr_q[0] <= d_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q[i] <= 1'b0;
        else        sr_q[i] <= sr_q[i-1];
      end
    end
  end

  assign d_out = sr_q[STAGES-1];
endmodule

// File: rtl/irc_pulse_qual.sv
module irc_pulse_qual #(
  parameter int unsigned MIN_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync,
  input  logic tick,
  output logic qual_rst
);
  localparam int unsigned CNT_W = $clog2(MIN_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_q, rst_d;

  always_comb begin
    cnt_d = cnt_q;
    rst_d = rst_q;
    if (!pin_sync) begin
      cnt_d = '0;
      rst_d = 1'b0;
    end else if (tick && !rst_q) begin
      if (cnt_q == LAST) rst_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign qual_rst = rst_q;
endmodule

// File: rtl/irc_idle_reg.sv
module irc_idle_reg #(
  parameter int unsigned N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_idle_bit,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             sys_rst,
  output logic             idle
);
  logic idle_q, idle_d;
  logic wake, set_req;

  always_comb begin
    wake    = |(irq_pend & irq_en);
    set_req = wr_en && wr_idle_bit && !idle_q;
    idle_d  = idle_q;
    if (sys_rst)      idle_d = 1'b0;
    else if (wake)    idle_d = 1'b0;
    else if (set_req) idle_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b0;
    else        idle_q <= idle_d;
  end

  assign idle = idle_q;
endmodule

// File: rtl/idle_reset_ctrl.sv
module idle_reset_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned N_IRQ       = IRC_N_IRQ,
  parameter int unsigned MIN_TICKS   = IRC_MIN_TICKS,
  parameter int unsigned SYNC_STAGES = IRC_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic             pwr_we,
  input  logic [7:0]       pwr_wdata,
  input  logic [N_IRQ-1:0] irq_pending,
  input  logic [N_IRQ-1:0] irq_enable,
  input  logic             ext_rst_pin,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             int_rst
);
  logic     pin_s;
  logic     qual_rst;
  logic     idle;
  irc_out_t outs;

  irc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (ext_rst_pin),
    .d_out (pin_s)
  );

  irc_pulse_qual #(.MIN_TICKS(MIN_TICKS)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_sync (pin_s),
    .tick     (mc_tick),
    .qual_rst (qual_rst)
  );

  irc_idle_reg #(.N_IRQ(N_IRQ)) u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (pwr_we),
    .wr_idle_bit (pwr_wdata[0]),
    .irq_pend    (irq_pending),
    .irq_en      (irq_enable),
    .sys_rst     (qual_rst),
    .idle        (idle)
  );

  always_comb begin
    outs.rst    = qual_rst;
    outs.per_en = !qual_rst;
    outs.cpu_en = !qual_rst && !idle;
  end

  assign cpu_clk_en = outs.cpu_en;
  assign per_clk_en = outs.per_en;
  assign int_rst    = outs.rst;
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int unsigned N_IRQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_tick,
  input logic             pwr_we,
  input logic [7:0]       pwr_wdata,
  input logic [N_IRQ-1:0] irq_pending,
  input logic [N_IRQ-1:0] irq_enable,
  input logic             ext_rst_pin,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             int_rst
);
  logic wake;
  assign wake = |(irq_pending & irq_enable);

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && pwr_we && pwr_wdata[0] && !wake |=> !cpu_clk_en && (per_clk_en || int_rst)); // R2
  AST_WAKE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en && !int_rst && wake |=> cpu_clk_en || int_rst); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en && per_clk_en && !wake |=> !cpu_clk_en); // R4
  AST_RST_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> !cpu_clk_en && !per_clk_en); // R9
  AST_RST_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> $past(mc_tick)); // R7
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst) |-> !$past(ext_rst_pin, 3)); // R8
endmodule

bind idle_reset_ctrl irc_checker #(.N_IRQ(N_IRQ)) u_irc_chk (
  .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .pwr_we(pwr_we),
  .pwr_wdata(pwr_wdata), .irq_pending(irq_pending), .irq_enable(irq_enable),
  .ext_rst_pin(ext_rst_pin), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
  .int_rst(int_rst)
);

// File: tb/idle_reset_ctrl_tb_top.sv
module idle_reset_ctrl_tb_top;
  localparam int NI = 4;
  localparam logic [2:0] RUN  = 3'b110;
  localparam logic [2:0] IDLE = 3'b010;
  localparam logic [2:0] RST  = 3'b001;

  logic clk = 1'b0;
  logic rst_n, mc_tick, pwr_we, ext_rst_pin;
  logic [7:0] pwr_wdata;
  logic [NI-1:0] irq_pending, irq_enable;
  logic cpu_clk_en, per_clk_en, int_rst;

  typedef struct { string tag; logic [2:0] exp; } item_t;
  item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  idle_reset_ctrl #(.N_IRQ(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .pwr_we(pwr_we),
    .pwr_wdata(pwr_wdata), .irq_pending(irq_pending), .irq_enable(irq_enable),
    .ext_rst_pin(ext_rst_pin), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .int_rst(int_rst)
  );

  // Driver side: advance one edge, then queue what the outputs must show.
  task automatic cyc(input string tag, input logic [2:0] exp);
    item_t it;
    @(posedge clk);
    #1;
    it.tag = tag;
    it.exp = exp;
    sb_q.push_back(it);
  endtask

  // Monitor: compare at the falling edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if ({cpu_clk_en, per_clk_en, int_rst} !== it.exp) begin
        failures++;
        $display("FAIL %s: {cpu,per,rst} actual=%b expected=%b",
                 it.tag, {cpu_clk_en, per_clk_en, int_rst}, it.exp);
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mc_tick = 1'b0; pwr_we = 1'b0; pwr_wdata = '0;
    irq_pending = '0; irq_enable = '0; ext_rst_pin = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc("R1 reset state", RUN);
    cyc("R1 reset state", RUN);

    pwr_we = 1'b1; pwr_wdata = 8'hFE;
    cyc("R5 write bit0=0 running", RUN);
    pwr_we = 1'b0;
    cyc("R5 still running", RUN);

    pwr_we = 1'b1; pwr_wdata = 8'h01;
    cyc("R2 idle entry", IDLE);
    pwr_we = 1'b0;
    cyc("R2 idle held, peripherals on", IDLE);

    irq_pending = 4'b0100; irq_enable = 4'b0011;
    cyc("R3 masked pending ignored", IDLE);
    cyc("R3 masked pending ignored", IDLE);

    pwr_we = 1'b1; pwr_wdata = 8'h00;
    cyc("R4 write 0 in idle ignored", IDLE);
    pwr_we = 1'b0;
    cyc("R4 still idle", IDLE);

    irq_enable = 4'b0111;
    cyc("R3 enabled interrupt wakes", RUN);
    irq_pending = '0; irq_enable = '0;
    cyc("R3 stays running", RUN);

    pwr_we = 1'b1; pwr_wdata = 8'h01; irq_pending = 4'b1000; irq_enable = 4'b1000;
    cyc("R6 wake beats idle write", RUN);
    pwr_we = 1'b0; irq_pending = '0; irq_enable = '0;
    cyc("R6 still running", RUN);

    pwr_we = 1'b1; pwr_wdata = 8'h01;
    cyc("R2 idle again", IDLE);
    pwr_we = 1'b0;

    // Short pulse: early ticks before sync settles, then only one counted tick.
    ext_rst_pin = 1'b1; mc_tick = 1'b1;
    cyc("R7 tick before sync ignored", IDLE);
    cyc("R7 tick before sync ignored", IDLE);
    cyc("R7 one tick no reset", IDLE);
    ext_rst_pin = 1'b0; mc_tick = 1'b0;
    cyc("R7 short pulse rejected", IDLE);
    cyc("R7 short pulse rejected", IDLE);
    cyc("R7 short pulse rejected", IDLE);

    // Qualified pulse: two ticks while synced pin high.
    ext_rst_pin = 1'b1;
    cyc("R7 sync stage 1", IDLE);
    cyc("R7 sync stage 2", IDLE);
    mc_tick = 1'b1;
    cyc("R7 first tick", IDLE);
    mc_tick = 1'b0;
    cyc("R7 between ticks", IDLE);
    mc_tick = 1'b1;
    cyc("R7 second tick asserts reset", RST);
    cyc("R8 reset held", RST);
    mc_tick = 1'b0;
    pwr_we = 1'b1; pwr_wdata = 8'h01;
    cyc("R10 write during reset", RST);
    pwr_we = 1'b0;
    cyc("R9 reset gates both", RST);
    ext_rst_pin = 1'b0;
    cyc("R8 release stage 1", RST);
    cyc("R8 release stage 2", RST);
    cyc("R8 R9 R10 released, idle cleared", RUN);
    cyc("R10 no idle left behind", RUN);

    pwr_we = 1'b1; pwr_wdata = 8'h03;
    cyc("R2 idle after reset", IDLE);
    pwr_we = 1'b0;
    cyc("R2 idle held", IDLE);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule